// File: doc/BRIEF.md
# Serial Controller Host Bus Interface

This block sits between a processor bus and the serial engines of a programmable serial controller. It decodes an active-low chip select, a control/data select line and active-low read and write strobes. Each access is steered to one of four places: the mode byte, the command byte, the status byte, or the transmit and receive data buffers. The data bus is 8 bits wide and split into an input, an output and an output enable. The output enable is high only during a selected read.

Mode writes and command writes share a single control address. A small sequencer decides which byte each control write reaches. After reset the first control write sets the mode. Every later control write sets the command, until a command asks for a return to mode entry. The command byte drives the modem handshake outputs and clears the error flags on request. A sampled data-set-ready input is reported in status. The transmitter and receiver engines connect through load/take handshakes and receive the stored mode and command bytes.

A write takes effect at the first clock edge where the write strobe is seen low after being high, with chip select low. A data read clears receiver-ready in the same way on the falling read strobe. Read data is combinational from the stored state.

Top module: `usart_host_if`

## Requirements
- R1: After reset, mode_o and cmd_o are 0x00, dtr_no and rts_no are high, the next control write is taken as a mode byte, and status reads 0x05 when tx_idle_i is high and dsr_ni is high.
- R2: While cs_ni is high, strobes have no effect: mode_o, cmd_o and tx_full_o do not change, and receiver-ready stays set.
- R3: The first control write (cd_i=1) after reset or after a return to mode entry loads mode_o. Each later control write loads cmd_o and leaves mode_o unchanged.
- R4: A command write with bit 6 set clears cmd_o to 0x00, and the next control write loads mode_o.
- R5: A data write (cd_i=0) loads tx_data_o and sets tx_full_o, which clears status bit 0 (transmitter ready). A tx_take_i pulse clears tx_full_o. Status bit 2 (transmit empty) equals tx_idle_i AND NOT tx_full_o.
- R6: A pulse on rx_load_i captures rx_data_i and sets status bit 1 (receiver ready). A data read returns the captured byte, and the falling read strobe clears status bit 1.
- R7: On rx_load_i, rx_perr_i sets status bit 3 and rx_ferr_i sets status bit 5. A load while receiver-ready is set and no read is in progress sets status bit 4 (overrun). A command write with bit 4 set clears bits 3, 4 and 5 and still stores the command.
- R8: dtr_no equals NOT cmd bit 1, and rts_no equals NOT cmd bit 5. Status bit 7 equals NOT dsr_ni as sampled one clock earlier. Status bit 6 reads 0.
- R9: data_oe_o is high only while cs_ni and rd_ni are both low. data_o then shows status when cd_i is high and the receive buffer when cd_i is low, and reads 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| cd_i | input | 1 | 1 = control/status, 0 = data buffers |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| data_i | input | 8 | Write data from processor |
| data_o | output | 8 | Read data to processor |
| data_oe_o | output | 1 | Output enable for the data bus |
| mode_o | output | 8 | Stored mode byte |
| cmd_o | output | 8 | Stored command byte |
| tx_data_o | output | 8 | Transmit buffer contents |
| tx_full_o | output | 1 | Transmit buffer holds a byte |
| tx_take_i | input | 1 | Transmitter takes the buffered byte |
| tx_idle_i | input | 1 | Transmit shifter is idle |
| rx_load_i | input | 1 | Receiver delivers a character |
| rx_data_i | input | 8 | Received character |
| rx_perr_i | input | 1 | Parity error on the delivered character |
| rx_ferr_i | input | 1 | Framing error on the delivered character |
| dsr_ni | input | 1 | Data set ready, active low |
| dtr_no | output | 1 | Data terminal ready, active low |
| rts_no | output | 1 | Request to send, active low |

## Verification
The assertions check five rules on every cycle. A deselected bus never alters the mode or command bytes. Command writes leave the mode byte untouched. A data write fills the transmit buffer. A data read drops receiver-ready. Back-to-back loads raise overrun, and an error-clear command empties the error flags. The bench scenarios cover the rest. They sweep all 256 mode and command values through the mode/command sequencer, including the return to mode entry. They round-trip all 256 received characters through the data port, and they combine the transmitter handshake, error latching and modem lines into exact status values.

// File: rtl/usart_pkg.sv
package usart_pkg;
  // command byte bit positions
  localparam int CMD_TXEN = 0;
  localparam int CMD_DTR  = 1;
  localparam int CMD_RXEN = 2;
  localparam int CMD_ERST = 4;
  localparam int CMD_RTS  = 5;
  localparam int CMD_IRST = 6;
  // status byte bit positions
  localparam int ST_TXRDY = 0;
  localparam int ST_RXRDY = 1;
  localparam int ST_TXE   = 2;
  localparam int ST_PE    = 3;
  localparam int ST_OE    = 4;
  localparam int ST_FE    = 5;
  localparam int ST_DSR   = 7;

  typedef enum logic {SEQ_MODE, SEQ_CMD} seq_e;

  typedef struct packed {
    logic fe;
    logic oe;
    logic pe;
  } err_t;
endpackage

// File: rtl/usart_bus_dec.sv
module usart_bus_dec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic cd_i,
  input  logic rd_ni,
  input  logic wr_ni,
  output logic ctl_wr_o,
  output logic dat_wr_o,
  output logic dat_rd_o,
  output logic oe_o
);
  logic wr_q, rd_q;
  logic wr_fall, rd_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= wr_ni;
      rd_q <= rd_ni;
    end
  end

  assign wr_fall  = wr_q && !wr_ni && !cs_ni;
  assign rd_fall  = rd_q && !rd_ni && !cs_ni;
  assign ctl_wr_o = wr_fall && cd_i;
  assign dat_wr_o = wr_fall && !cd_i;
  assign dat_rd_o = rd_fall && !cd_i;
  assign oe_o     = !cs_ni && !rd_ni;
endmodule

// File: rtl/usart_ctrl_regs.sv
module usart_ctrl_regs
  import usart_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mode_o,
  output logic [DW-1:0] cmd_o,
  output logic          err_clr_o
);
  seq_e          seq_q;
  logic [DW-1:0] mode_q, cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q  <= SEQ_MODE;
      mode_q <= '0;
      cmd_q  <= '0;
    end else if (ctl_wr_i) begin
      if (seq_q == SEQ_MODE) begin
        mode_q <= wdata_i;
        seq_q  <= SEQ_CMD;
      end else if (wdata_i[CMD_IRST]) begin
        cmd_q <= '0;
        seq_q <= SEQ_MODE;
      end else begin
        cmd_q <= wdata_i;
      end
    end
  end

  assign err_clr_o = ctl_wr_i && (seq_q == SEQ_CMD) &&
                     (wdata_i[CMD_ERST] || wdata_i[CMD_IRST]);
  assign mode_o = mode_q;
  assign cmd_o  = cmd_q;

  assert_mode_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && seq_q == SEQ_CMD) |=> $stable(mode_q));
endmodule

// File: rtl/usart_data_path.sv
module usart_data_path
  import usart_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dat_wr_i,
  input  logic          dat_rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          err_clr_i,
  input  logic          tx_take_i,
  input  logic          tx_idle_i,
  input  logic          rx_load_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_perr_i,
  input  logic          rx_ferr_i,
  input  logic          dsr_ni,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_full_o,
  output logic [DW-1:0] rx_buf_o,
  output logic [DW-1:0] status_o
);
  logic [DW-1:0] tx_q, rx_q;
  logic          tx_full_q, rx_rdy_q, dsr_q;
  err_t          err_q, err_d;

  always_comb begin
    err_d = err_clr_i ? '0 : err_q;
    if (rx_load_i) begin
      err_d.pe = err_d.pe | rx_perr_i;
      err_d.fe = err_d.fe | rx_ferr_i;
      err_d.oe = err_d.oe | (rx_rdy_q && !dat_rd_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q      <= '0;
      rx_q      <= '0;
      tx_full_q <= 1'b0;
      rx_rdy_q  <= 1'b0;
      dsr_q     <= 1'b0;
      err_q     <= '0;
    end else begin
      if (dat_wr_i) begin
        tx_q      <= wdata_i;
        tx_full_q <= 1'b1;
      end else if (tx_take_i) begin
        tx_full_q <= 1'b0;
      end
      if (rx_load_i) begin
        rx_q     <= rx_data_i;
        rx_rdy_q <= 1'b1;
      end else if (dat_rd_i) begin
        rx_rdy_q <= 1'b0;
      end
      err_q <= err_d;
      dsr_q <= !dsr_ni;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[ST_TXRDY] = !tx_full_q;
    status_o[ST_RXRDY] = rx_rdy_q;
    status_o[ST_TXE]   = !tx_full_q && tx_idle_i;
    status_o[ST_PE]    = err_q.pe;
    status_o[ST_OE]    = err_q.oe;
    status_o[ST_FE]    = err_q.fe;
    status_o[ST_DSR]   = dsr_q;
  end

  assign tx_data_o = tx_q;
  assign tx_full_o = tx_full_q;
  assign rx_buf_o  = rx_q;

  assert_tx_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_wr_i |=> tx_full_q);
  assert_rx_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_rd_i && !rx_load_i) |=> !rx_rdy_q);
  assert_overrun_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_load_i && rx_rdy_q && !dat_rd_i) |=> err_q.oe);
endmodule

// File: rtl/usart_host_if.sv
module usart_host_if
  import usart_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          cd_i,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic [DW-1:0] mode_o,
  output logic [DW-1:0] cmd_o,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_full_o,
  input  logic          tx_take_i,
  input  logic          tx_idle_i,
  input  logic          rx_load_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_perr_i,
  input  logic          rx_ferr_i,
  input  logic          dsr_ni,
  output logic          dtr_no,
  output logic          rts_no
);
  logic          ctl_wr, dat_wr, dat_rd, oe, err_clr;
  logic [DW-1:0] status, rx_buf;

  usart_bus_dec u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .cd_i(cd_i),
    .rd_ni(rd_ni), .wr_ni(wr_ni), .ctl_wr_o(ctl_wr), .dat_wr_o(dat_wr),
    .dat_rd_o(dat_rd), .oe_o(oe)
  );

  usart_ctrl_regs #(.DW(DW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_wr_i(ctl_wr), .wdata_i(data_i),
    .mode_o(mode_o), .cmd_o(cmd_o), .err_clr_o(err_clr)
  );

  usart_data_path #(.DW(DW)) u_data (
    .clk_i(clk_i), .rst_ni(rst_ni), .dat_wr_i(dat_wr), .dat_rd_i(dat_rd),
    .wdata_i(data_i), .err_clr_i(err_clr), .tx_take_i(tx_take_i),
    .tx_idle_i(tx_idle_i), .rx_load_i(rx_load_i), .rx_data_i(rx_data_i),
    .rx_perr_i(rx_perr_i), .rx_ferr_i(rx_ferr_i), .dsr_ni(dsr_ni),
    .tx_data_o(tx_data_o), .tx_full_o(tx_full_o), .rx_buf_o(rx_buf),
    .status_o(status)
  );

  assign data_oe_o = oe;
  assign data_o    = !oe ? '0 : (cd_i ? status : rx_buf);
  assign dtr_no    = !cmd_o[CMD_DTR];
  assign rts_no    = !cmd_o[CMD_RTS];

  assert_quiet_bus_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> ($stable(mode_o) && $stable(cmd_o)));
  assert_err_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr && !rx_load_i) |=> (status[ST_FE:ST_PE] == '0));
endmodule

// File: tb/usart_host_if_tb.sv
module usart_host_if_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, cd_i = 1'b0, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [7:0] data_i = '0;
  logic [7:0] data_o, mode_o, cmd_o, tx_data_o;
  logic       data_oe_o, tx_full_o, dtr_no, rts_no;
  logic       tx_take_i = 1'b0, tx_idle_i = 1'b1;
  logic       rx_load_i = 1'b0, rx_perr_i = 1'b0, rx_ferr_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       dsr_ni = 1'b1;
  int total = 0, bad = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  usart_host_if u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .cd_i(cd_i), .rd_ni(rd_ni),
    .wr_ni(wr_ni), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
    .mode_o(mode_o), .cmd_o(cmd_o), .tx_data_o(tx_data_o), .tx_full_o(tx_full_o),
    .tx_take_i(tx_take_i), .tx_idle_i(tx_idle_i), .rx_load_i(rx_load_i),
    .rx_data_i(rx_data_i), .rx_perr_i(rx_perr_i), .rx_ferr_i(rx_ferr_i),
    .dsr_ni(dsr_ni), .dtr_no(dtr_no), .rts_no(rts_no)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic cd, input logic [7:0] v);
    @(negedge clk);
    cs_ni = sel; cd_i = cd; data_i = v; wr_ni = 1'b0;
    @(negedge clk);
    wr_ni = 1'b1; cs_ni = 1'b1;
  endtask

  task automatic bus_rd(input logic sel, input logic cd, output logic [7:0] v);
    @(negedge clk);
    cs_ni = sel; cd_i = cd; rd_ni = 1'b0;
    #1 v = data_o;
    @(negedge clk);
    rd_ni = 1'b1; cs_ni = 1'b1;
  endtask

  task automatic rx_push(input logic [7:0] v, input logic pe, input logic fe);
    @(negedge clk);
    rx_load_i = 1'b1; rx_data_i = v; rx_perr_i = pe; rx_ferr_i = fe;
    @(negedge clk);
    rx_load_i = 1'b0; rx_perr_i = 1'b0; rx_ferr_i = 1'b0;
  endtask

  function automatic logic [7:0] exp_st(input logic dsr, input logic fe, input logic oe,
      input logic pe, input logic txe, input logic rxr, input logic txr);
    return {dsr, 1'b0, fe, oe, pe, txe, rxr, txr};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1 mode", mode_o, 8'h00);
    check("R1 cmd", cmd_o, 8'h00);
    check("R1 modem", {6'b0, dtr_no, rts_no}, 8'h03);
    bus_rd(1'b0, 1'b1, rv);
    check("R1 status", rv, 8'h05);
    // R9 output enable
    @(negedge clk);
    cs_ni = 1'b0; cd_i = 1'b1;
    #1 check("R9 oe no read", {7'b0, data_oe_o}, 8'h00);
    check("R9 data idle", data_o, 8'h00);
    cs_ni = 1'b1; rd_ni = 1'b0;
    #1 check("R9 oe no cs", {7'b0, data_oe_o}, 8'h00);
    cs_ni = 1'b0;
    #1 check("R9 oe read", {7'b0, data_oe_o}, 8'h01);
    rd_ni = 1'b1; cs_ni = 1'b1;

    // R2 deselected write has no effect; R1 first write still mode
    bus_wr(1'b1, 1'b1, 8'hFF);
    bus_wr(1'b1, 1'b0, 8'h77);
    check("R2 mode", mode_o, 8'h00);
    check("R2 cmd", cmd_o, 8'h00);
    check("R2 txfull", {7'b0, tx_full_o}, 8'h00);

    // R3 R4 R8 sweep of all mode/command values
    for (int v = 0; v < 256; v++) begin
      logic [7:0] m, c;
      m = v[7:0];
      c = m & 8'hBF;
      bus_wr(1'b0, 1'b1, m);
      bus_wr(1'b0, 1'b1, c);
      check("R3 mode", mode_o, m);
      check("R3 cmd", cmd_o, c);
      check("R8 dtr rts", {6'b0, dtr_no, rts_no}, {6'b0, ~c[1], ~c[5]});
      bus_wr(1'b0, 1'b1, 8'hC0 | c);
      check("R4 cmd clear", cmd_o, 8'h00);
      check("R4 mode kept", mode_o, m);
    end
    // R4 next write goes to mode
    bus_wr(1'b0, 1'b1, 8'h4E);
    check("R4 remode", mode_o, 8'h4E);
    bus_wr(1'b0, 1'b1, 8'h25);
    check("R3 cmd after", cmd_o, 8'h25);
    check("R3 mode held", mode_o, 8'h4E);

    // R5 transmit buffer
    bus_wr(1'b0, 1'b0, 8'hA5);
    check("R5 txdata", tx_data_o, 8'hA5);
    check("R5 txfull", {7'b0, tx_full_o}, 8'h01);
    bus_rd(1'b0, 1'b1, rv);
    check("R5 status full", rv, exp_st(0, 0, 0, 0, 0, 0, 0));
    @(negedge clk); tx_take_i = 1'b1;
    @(negedge clk); tx_take_i = 1'b0;
    check("R5 taken", {7'b0, tx_full_o}, 8'h00);
    bus_rd(1'b0, 1'b1, rv);
    check("R5 status empty", rv, exp_st(0, 0, 0, 0, 1, 0, 1));
    tx_idle_i = 1'b0;
    bus_rd(1'b0, 1'b1, rv);
    check("R5 shifter busy", rv, exp_st(0, 0, 0, 0, 0, 0, 1));
    tx_idle_i = 1'b1;

    // R6 receive round trip, all values
    for (int v = 0; v < 256; v++) begin
      rx_push(v[7:0], 1'b0, 1'b0);
      bus_rd(1'b0, 1'b1, rv);
      check("R6 rxrdy set", rv & 8'h02, 8'h02);
      bus_rd(1'b0, 1'b0, rv);
      check("R6 rx data", rv, v[7:0]);
      bus_rd(1'b0, 1'b1, rv);
      check("R6 rxrdy clr", rv & 8'h02, 8'h00);
    end

    // R2 deselected read does not clear receiver ready
    rx_push(8'h3C, 1'b0, 1'b0);
    bus_rd(1'b1, 1'b0, rv);
    bus_rd(1'b0, 1'b1, rv);
    check("R2 rxrdy kept", rv, exp_st(0, 0, 0, 0, 1, 1, 1));
    bus_rd(1'b0, 1'b0, rv);

    // R7 error flags
    rx_push(8'h11, 1'b1, 1'b0);
    bus_rd(1'b0, 1'b1, rv);
    check("R7 parity", rv, exp_st(0, 0, 0, 1, 1, 1, 1));
    rx_push(8'h12, 1'b0, 1'b1);
    bus_rd(1'b0, 1'b1, rv);
    check("R7 framing+overrun", rv, exp_st(0, 1, 1, 1, 1, 1, 1));
    bus_wr(1'b0, 1'b1, 8'h10);
    check("R7 cmd stored", cmd_o, 8'h10);
    bus_rd(1'b0, 1'b1, rv);
    check("R7 cleared", rv, exp_st(0, 0, 0, 0, 1, 1, 1));
    bus_rd(1'b0, 1'b0, rv);
    check("R7 last data", rv, 8'h12);

    // R8 data set ready
    dsr_ni = 1'b0;
    bus_rd(1'b0, 1'b1, rv);
    check("R8 dsr on", rv, exp_st(1, 0, 0, 0, 1, 0, 1));
    dsr_ni = 1'b1;
    bus_rd(1'b0, 1'b1, rv);
    check("R8 dsr off", rv, exp_st(0, 0, 0, 0, 1, 0, 1));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule